// File: doc/BRIEF.md
# Serial Converter Sequencer with In-Band Power Control

This block is the digital side of a sampling analog-to-digital converter. It watches two asynchronous pins: a convert-start strobe and a serial clock from the host. A rising strobe starts a conversion. The block latches the 14-bit word that the converter core presents on a parallel port and shifts that word out on a serial data line, one bit per rising serial clock. The data line has an output enable, so the pad can float outside the data window. The word presented at a strobe is the result of the conversion before it. The stub or core is expected to hold the previous result on the port, and the block keeps whatever it latched, however the port changes afterwards.

The host also commands power-down without extra pins. It sends strobes while the serial clock sits still, either high or low. Two or three such strobes park the block in nap, and four or more park it in sleep. While parked, the block launches no conversion and keeps the data line floating. Any serial clock edge, rising or falling, returns it to active mode. The next strobe then starts a normal conversion.

Both pins pass through two-flop synchronizers into the system clock domain. The block detects edges on the synchronized signals.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `conv_start` is 0, `sdo_oe` is 0 and `mode` is active (code 2'b00).
- R2: A rising `cnv_in` in active mode raises `conv_start` for exactly one system clock. It is seen at the third rising `clk` edge after the pin changes and is low again at the fourth.
- R3: At a launch, the block latches the value of `conv_data`, raises `sdo_oe`, and drives bit 13 on `sdo` in the same cycle as `conv_start`.
- R4: Each synchronized rising `sclk_in` moves `sdo` to the next lower bit, most-significant bit first. After the 14th rising edge, `sdo_oe` is 0.
- R5: A falling `sclk_in` never changes `sdo`.
- R6: A second `cnv_in` rising edge with no `sclk_in` edge since the previous one enters nap (`mode` 2'b01), launches nothing, and drops `sdo_oe`. This holds with the clock held high or held low.
- R7: A third static-clock strobe leaves `mode` in nap. A fourth or later strobe sets sleep (`mode` 2'b10).
- R8: Any `sclk_in` edge clears the strobe count and returns nap or sleep to active. The next strobe is a normal conversion, and sleep never moves directly to nap.
- R9: In nap or sleep, `conv_start` stays 0 and `sdo_oe` stays 0.
- R10: `mode` never shows the code 2'b11.
- R11: Changes on `conv_data` after a launch do not alter the bits shifted out for that launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_in | input | 1 | Asynchronous convert-start strobe |
| sclk_in | input | 1 | Asynchronous serial clock from the host |
| conv_data | input | 14 | Result word from the converter core |
| conv_start | output | 1 | One-cycle pulse that starts a conversion in the core |
| sdo | output | 1 | Serial data bit, 0 while disabled |
| sdo_oe | output | 1 | Output enable for the three-state data pad |
| mode | output | 2 | Power state: 00 active, 01 nap, 10 sleep |

## Verification
A pin change enters two synchronizer flops and then updates the registered state. Every result of a pin change therefore appears at the third rising `clk` edge after the change. The bench drives pins just after a falling edge. For the strobe pulse it samples on the falling edges after the second, third and fourth rising edges, so it checks that the pulse has not yet appeared, is present, and is gone. Every other stimulus is followed by four rising edges before the outputs are sampled on a falling edge, by which point mode, enable and data bit have settled. The sweep covers 24 computed data words, each read back bit by bit on both serial clock edges.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    localparam int WORD_W = 14;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'b00,
        PM_NAP    = 2'b01,
        PM_SLEEP  = 2'b10
    } pmode_t;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_ev_t;

    // Power state reached after a strobe that brings the static-clock count to n.
    function automatic pmode_t pm_after_strobe(input int unsigned n,
                                               input int unsigned nap_n,
                                               input int unsigned sleep_n,
                                               input pmode_t cur);
        if (n >= sleep_n) return PM_SLEEP;
        if (n >= nap_n)   return (cur == PM_SLEEP) ? PM_SLEEP : PM_NAP;
        return cur;
    endfunction

endpackage

// File: rtl/adc_sync_edge.sv
`timescale 1ns/1ps
module adc_sync_edge
    import adc_seq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pin_i,
    output pin_ev_t ev_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        ev_o.level = chain_q[STAGES-1];
        ev_o.rise  = chain_q[STAGES-1] & ~last_q;
        ev_o.fall  = ~chain_q[STAGES-1] & last_q;
    end
endmodule

// File: rtl/adc_pwr_ctrl.sv
`timescale 1ns/1ps
module adc_pwr_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NAP_PULSES   = 2,
    parameter int SLEEP_PULSES = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe_i,
    input  logic   clk_edge_i,
    output pmode_t mode_o,
    output logic   launch_o,
    output logic   park_o
);
    localparam int CNT_W = $clog2(SLEEP_PULSES + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SLEEP_PULSES);

    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    pmode_t           mode_q, mode_d;

    always_comb begin
        cnt_inc = (cnt_q >= CNT_SAT) ? CNT_SAT : cnt_q + 1'b1;
        cnt_d   = cnt_q;
        mode_d  = mode_q;
        if (clk_edge_i) begin
            cnt_d  = strobe_i ? CNT_W'(1) : '0;
            mode_d = PM_ACTIVE;
        end else if (strobe_i) begin
            cnt_d  = cnt_inc;
            mode_d = pm_after_strobe(int'(cnt_inc), NAP_PULSES, SLEEP_PULSES, mode_q);
        end
    end

    assign launch_o = strobe_i && (mode_d == PM_ACTIVE);
    assign park_o   = strobe_i && (mode_d != PM_ACTIVE);
    assign mode_o   = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= PM_ACTIVE;
        end else begin
            cnt_q  <= cnt_d;
            mode_q <= mode_d;
        end
    end
endmodule

// File: rtl/adc_shift_out.sv
`timescale 1ns/1ps
module adc_shift_out #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch_i,
    input  logic              park_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              sdo_o,
    output logic              oe_o
);
    localparam int LEFT_W = $clog2(DATA_W + 1);
    localparam logic [LEFT_W-1:0] FULL = LEFT_W'(DATA_W);

    logic [DATA_W-1:0] word_q;
    logic [LEFT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            left_q <= '0;
        end else if (launch_i) begin
            word_q <= data_i;
            left_q <= FULL;
        end else if (park_i) begin
            left_q <= '0;
        end else if (shift_i && left_q != '0) begin
            word_q <= {word_q[DATA_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign oe_o  = (left_q != '0);
    assign sdo_o = oe_o & word_q[DATA_W-1];
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W       = WORD_W,
    parameter int SYNC_STAGES  = 2,
    parameter int NAP_PULSES   = 2,
    parameter int SLEEP_PULSES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnv_in,
    input  logic              sclk_in,
    input  logic [DATA_W-1:0] conv_data,
    output logic              conv_start,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [1:0]        mode
);
    pin_ev_t cnv_ev, sclk_ev;
    pmode_t  pm;
    logic    launch, park, start_q;

    adc_sync_edge #(.STAGES(SYNC_STAGES)) u_cnv_sync (
        .clk(clk), .rst(rst), .pin_i(cnv_in), .ev_o(cnv_ev)
    );

    adc_sync_edge #(.STAGES(SYNC_STAGES)) u_sclk_sync (
        .clk(clk), .rst(rst), .pin_i(sclk_in), .ev_o(sclk_ev)
    );

    adc_pwr_ctrl #(.NAP_PULSES(NAP_PULSES), .SLEEP_PULSES(SLEEP_PULSES)) u_pwr (
        .clk(clk), .rst(rst),
        .strobe_i(cnv_ev.rise),
        .clk_edge_i(sclk_ev.rise | sclk_ev.fall),
        .mode_o(pm), .launch_o(launch), .park_o(park)
    );

    adc_shift_out #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst),
        .launch_i(launch), .park_i(park), .shift_i(sclk_ev.rise),
        .data_i(conv_data), .sdo_o(sdo), .oe_o(sdo_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= launch;
    end

    assign conv_start = start_q;
    assign mode       = pm;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       conv_start,
    input logic       sdo_oe,
    input logic [1:0] mode
);
    p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    p_oe_opens_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> conv_start);

    p_sleep_no_nap_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |=> (mode != 2'b01));

    p_no_start_parked_r9: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (mode == 2'b00));

    p_float_parked_r9: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00) |-> !sdo_oe);

    p_mode_code_r10: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .conv_start(conv_start), .sdo_oe(sdo_oe), .mode(mode)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnv_in = 1'b0;
    logic         sclk_in = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic         conv_start, sdo, sdo_oe;
    logic [1:0]   mode;

    int total = 0;
    int fails = 0;
    int starts = 0;
    bit done = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .cnv_in(cnv_in), .sclk_in(sclk_in),
        .conv_data(conv_data), .conv_start(conv_start), .sdo(sdo),
        .sdo_oe(sdo_oe), .mode(mode)
    );

    always @(negedge clk) if (!rst && conv_start) starts++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_sclk(input logic v);
        sclk_in = v;
        step(4);
    endtask

    // Strobe with fine sampling of conv_start after rising clk edges 2, 3 and 4.
    task automatic strobe(output logic s2, output logic s3, output logic s4);
        cnv_in = 1'b1;
        step(2); s2 = conv_start;
        step(1); s3 = conv_start;
        step(1); s4 = conv_start;
        cnv_in = 1'b0;
        step(4);
    endtask

    function automatic logic [W-1:0] pattern(input int k);
        case (k)
            0: return 14'h0000;
            1: return 14'h3FFF;
            2: return 14'h2AAA;
            3: return 14'h1555;
            4: return 14'h2000;
            5: return 14'h0001;
            default: return W'((k * 32'h1F3D + 32'h00A5) & 32'h3FFF);
        endcase
    endfunction

    task automatic read_word(input logic [W-1:0] exp);
        chk("R3 oe at launch", sdo_oe, 1);
        chk("R3 msb at launch", sdo, exp[W-1]);
        for (int i = W - 2; i >= 0; i--) begin
            set_sclk(1'b1);
            chk("R4 bit after rise", sdo, exp[i]);
            chk("R4 oe in window", sdo_oe, 1);
            set_sclk(1'b0);
            chk("R5 bit held on fall", sdo, exp[i]);
        end
        set_sclk(1'b1);
        chk("R4 oe off after 14 rises", sdo_oe, 0);
        set_sclk(1'b0);
    endtask

    task automatic conversion(input logic [W-1:0] val, input string tag);
        logic a, b, c;
        conv_data = val;
        strobe(a, b, c);
        chk({"R2 no pulse at edge 2 ", tag}, a, 0);
        chk({"R2 pulse at edge 3 ", tag}, b, 1);
        chk({"R2 pulse gone at edge 4 ", tag}, c, 0);
        chk({"R8 active mode ", tag}, mode, 2'b00);
        conv_data = ~val;   // R11: later port changes must not reach the output
        read_word(val);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic a, b, c;
        int s0;
        step(3);
        chk("R1 start in reset", conv_start, 0);
        chk("R1 oe in reset", sdo_oe, 0);
        chk("R1 mode in reset", mode, 2'b00);
        rst = 1'b0;
        step(1);
        chk("R1 start after reset", conv_start, 0);
        chk("R1 oe after reset", sdo_oe, 0);
        chk("R1 mode after reset", mode, 2'b00);

        for (int k = 0; k < 24; k++) conversion(pattern(k), "sweep");

        // Static clock low: count strobes into nap and sleep.
        conv_data = 14'h0F0F;
        s0 = starts;
        strobe(a, b, c);
        chk("R2 first static strobe launches", b, 1);
        chk("R3 window open", sdo_oe, 1);
        strobe(a, b, c);
        chk("R6 second strobe: nap", mode, 2'b01);
        chk("R6 no launch on nap", starts - s0, 1);
        chk("R6 window closed", sdo_oe, 0);
        strobe(a, b, c);
        chk("R7 third strobe stays nap", mode, 2'b01);
        chk("R9 no launch in nap", starts - s0, 1);
        strobe(a, b, c);
        chk("R7 fourth strobe: sleep", mode, 2'b10);
        strobe(a, b, c);
        chk("R7 fifth strobe stays sleep", mode, 2'b10);
        chk("R9 no launch in sleep", starts - s0, 1);
        chk("R9 float in sleep", sdo_oe, 0);
        set_sclk(1'b1);
        chk("R8 rise wakes from sleep", mode, 2'b00);
        chk("R8 still floating", sdo_oe, 0);
        set_sclk(1'b0);
        conversion(14'h2D3C, "after sleep");

        // Static clock high: nap, then a falling edge wakes.
        set_sclk(1'b1);
        conv_data = 14'h1234;
        s0 = starts;
        strobe(a, b, c);
        chk("R2 launch with clock high", b, 1);
        strobe(a, b, c);
        chk("R6 nap with clock high", mode, 2'b01);
        chk("R6 no launch clock high", starts - s0, 1);
        set_sclk(1'b0);
        chk("R8 fall wakes from nap", mode, 2'b00);
        conversion(14'h3A5C, "after nap");

        // Clock edges between strobes clear the count.
        conv_data = 14'h0421;
        strobe(a, b, c);
        chk("R2 launch before clear", b, 1);
        set_sclk(1'b1);
        set_sclk(1'b0);
        conv_data = 14'h3333;
        strobe(a, b, c);
        chk("R8 count cleared: launch", b, 1);
        chk("R8 count cleared: active", mode, 2'b00);
        conv_data = 14'h0CCC;
        read_word(14'h3333);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule